// File: doc/BRIEF.md
# Banked GPIO and Pad Function Controller

This block manages up to 56 general-purpose pins through a small register bus. Pins are grouped into ports of sixteen. For every pin it stores an output value, a direction, a two-bit function code, an open-drain flag and pull settings, and it drives the pad's output, output enable and pull controls from them. A pin with a nonzero function code is handed to one of three alternate peripherals. Those peripherals supply the pad's output and enable and receive the synchronised pad level.

Each port has a register window of 0x30 bytes. The fourth port has only eight pins. It keeps its own output, input, direction and function-select-low registers. Its open-drain, pull and function-select-high registers are placed in unused slots of the first two windows. Software reads pad levels through a two-stage synchroniser. The bus is a plain single-cycle register interface with no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and `rd_data` follows `addr` combinationally in the same cycle.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset every stored bit is 0. Every pin is then a GPIO input with the output enable low, no pull, and the output low.
- R2: Pin i belongs to port i/16 at bit i%16. Port p's window starts at byte 0x30*p. The offsets in that window are: output 0x00, input 0x04, direction 0x08, function-select-low 0x0C, function-select-high 0x10, open-drain 0x14, pull-select 0x1C, pull-enable 0x20. Each readable register returns the bits that were written to it, on `rd_data[15:0]`.
- R3: For port 3, open-drain is at 0x24, pull-select at 0x28 and pull-enable at 0x2C. Function-select-high is at 0x54. Port 3's own window still holds output 0x90, input 0x94, direction 0x98 and function-select-low 0x9C. Writing these relocated registers leaves the port 0 and port 1 registers unchanged.
- R4: A register bit for a pin index at or above NUM_PINS reads 0 and ignores writes.
- R5: With function code 0, `pad_out` follows the output bit and `pad_oe` follows the direction bit (1 = output).
- R6: The function code is {function-select-high, function-select-low}. A code c from 1 to 3 takes `pad_out` and `pad_oe` from `alt_out[c-1]` and `alt_oe[c-1]`. It also presents the synchronised pad level on `alt_in[c-1]`. All other `alt_in` bits of that pin are 0.
- R7: With the open-drain bit set, `pad_oe` is forced low whenever the selected output value is 1. This applies in both GPIO and alternate modes.
- R8: With pull-enable 0 there is no pull. With pull-enable 1, pull-select 1 asserts `pad_pull_up` and pull-select 0 asserts `pad_pull_dn`.
- R9: The input register shows `pad_in` through two flops. A level applied before clock edge k appears after edge k+1, whatever the function code.
- R10: Reads of unmapped addresses return 0. Writes to an input register, or to any unmapped address, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| pad_in | input | NUM_PINS | Pad levels |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_up | output | NUM_PINS | Pull-up request |
| pad_pull_dn | output | NUM_PINS | Pull-down request |
| alt_out | input | 3 x NUM_PINS | Output value from alternate functions 1..3 |
| alt_oe | input | 3 x NUM_PINS | Output enable from alternate functions 1..3 |
| alt_in | output | 3 x NUM_PINS | Synchronised pad level to alternate functions 1..3 |

## Verification
The bench concentrates on the port-3 relocation. A decoder that missed the relocation would alias the spare slots onto port 0 or port 1 open-drain and function-select registers, or would leave pin 48 stuck in GPIO mode. It also targets the unpopulated upper half of port 3: a missing mask would read back ones there. The two-cycle input latency is checked on both sides: a synchroniser one stage short shows the new level a cycle early, and one stage too long shows it a cycle late. Open-drain is exercised with an alternate function driving a 1, where a design that applied it only in GPIO mode would keep the pad enabled.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam int unsigned PORT_PINS  = 16;
  localparam int unsigned WIN_BYTES  = 'h30;
  localparam int unsigned SPARE_PORT = 3;
  localparam int unsigned NUM_ALT    = 3;

  // stored kinds first, the sampled input last (it has no storage)
  typedef enum logic [2:0] {
    RK_OUT  = 3'd0,
    RK_DIR  = 3'd1,
    RK_FS0  = 3'd2,
    RK_FS1  = 3'd3,
    RK_OD   = 3'd4,
    RK_PSEL = 3'd5,
    RK_PEN  = 3'd6,
    RK_IN   = 3'd7
  } reg_kind_e;

  localparam int unsigned NUM_STORED = 7;

  // byte address of one register of one port, with the short port's relocations
  function automatic int unsigned reg_addr(int unsigned port, reg_kind_e kind);
    int unsigned base;
    bit          spare;
    base  = WIN_BYTES * port;
    spare = (port == SPARE_PORT);
    case (kind)
      RK_OUT:  return base;
      RK_IN:   return base + 'h04;
      RK_DIR:  return base + 'h08;
      RK_FS0:  return base + 'h0C;
      RK_FS1:  return spare ? (WIN_BYTES + 'h24) : (base + 'h10);
      RK_OD:   return spare ? 'h24 : (base + 'h14);
      RK_PSEL: return spare ? 'h28 : (base + 'h1C);
      default: return spare ? 'h2C : (base + 'h20);
    endcase
  endfunction
endpackage

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 56,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [15:0]         wr_data,
  input  logic [NUM_PINS-1:0] in_bits,
  output logic [15:0]         rd_data,
  output logic [NUM_PINS-1:0] out_bits,
  output logic [NUM_PINS-1:0] dir_bits,
  output logic [NUM_PINS-1:0] fs0_bits,
  output logic [NUM_PINS-1:0] fs1_bits,
  output logic [NUM_PINS-1:0] od_bits,
  output logic [NUM_PINS-1:0] psel_bits,
  output logic [NUM_PINS-1:0] pen_bits
);
  localparam int unsigned NUM_PORTS = (NUM_PINS + PORT_PINS - 1) / PORT_PINS;
  localparam int unsigned FLAT      = NUM_PORTS * PORT_PINS;
  localparam logic [FLAT-1:0] VALID = {FLAT{1'b1}} >> (FLAT - NUM_PINS);

  logic [FLAT-1:0] store [NUM_STORED];
  logic [FLAT-1:0] in_flat;

  assign in_flat = FLAT'(in_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_STORED; k++) store[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_STORED; k++) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (addr == ADDR_W'(reg_addr(p, reg_kind_e'(k))))
            store[k][p*PORT_PINS +: PORT_PINS] <= wr_data & VALID[p*PORT_PINS +: PORT_PINS];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_STORED; k++) begin
        if (addr == ADDR_W'(reg_addr(p, reg_kind_e'(k))))
          rd_data = rd_data | store[k][p*PORT_PINS +: PORT_PINS];
      end
      if (addr == ADDR_W'(reg_addr(p, RK_IN)))
        rd_data = rd_data | in_flat[p*PORT_PINS +: PORT_PINS];
    end
  end

  assign out_bits  = store[RK_OUT][NUM_PINS-1:0];
  assign dir_bits  = store[RK_DIR][NUM_PINS-1:0];
  assign fs0_bits  = store[RK_FS0][NUM_PINS-1:0];
  assign fs1_bits  = store[RK_FS1][NUM_PINS-1:0];
  assign od_bits   = store[RK_OD][NUM_PINS-1:0];
  assign psel_bits = store[RK_PSEL][NUM_PINS-1:0];
  assign pen_bits  = store[RK_PEN][NUM_PINS-1:0];
endmodule

// File: rtl/gpio_pinmux_sync.sv
module gpio_pinmux_sync #(
  parameter int unsigned W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pinmux_lane.sv
module gpio_pinmux_lane
  import gpio_pinmux_pkg::*;
(
  input  logic               gpio_out,
  input  logic               gpio_dir,
  input  logic               fs0,
  input  logic               fs1,
  input  logic               od,
  input  logic               pen,
  input  logic               psel,
  input  logic               in_sync,
  input  logic [NUM_ALT-1:0] alt_out,
  input  logic [NUM_ALT-1:0] alt_oe,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               pull_up,
  output logic               pull_dn,
  output logic [NUM_ALT-1:0] alt_in
);
  logic [1:0] code;
  logic [1:0] sel;
  logic       drv;
  logic       en;

  assign code = {fs1, fs0};
  assign sel  = code - 2'd1;

  always_comb begin
    drv    = gpio_out;
    en     = gpio_dir;
    alt_in = '0;
    if (code != 2'd0) begin
      drv         = alt_out[sel];
      en          = alt_oe[sel];
      alt_in[sel] = in_sync;
    end
  end

  assign pad_out = drv;
  assign pad_oe  = en & ~(od & drv);
  assign pull_up = pen & psel;
  assign pull_dn = pen & ~psel;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 56,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr_en,
  input  logic [15:0]                       wr_data,
  output logic [15:0]                       rd_data,
  input  logic [NUM_PINS-1:0]               pad_in,
  output logic [NUM_PINS-1:0]               pad_out,
  output logic [NUM_PINS-1:0]               pad_oe,
  output logic [NUM_PINS-1:0]               pad_pull_up,
  output logic [NUM_PINS-1:0]               pad_pull_dn,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_out,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_oe,
  output logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_in
);
  logic [NUM_PINS-1:0] out_bits, dir_bits, fs0_bits, fs1_bits;
  logic [NUM_PINS-1:0] od_bits, psel_bits, pen_bits, sync_bits;
  logic [NUM_ALT-1:0]  lane_ao [NUM_PINS];
  logic [NUM_ALT-1:0]  lane_ae [NUM_PINS];
  logic [NUM_ALT-1:0]  lane_ai [NUM_PINS];

  gpio_pinmux_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_bits)
  );

  gpio_pinmux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .in_bits(sync_bits), .rd_data(rd_data),
    .out_bits(out_bits), .dir_bits(dir_bits), .fs0_bits(fs0_bits),
    .fs1_bits(fs1_bits), .od_bits(od_bits), .psel_bits(psel_bits),
    .pen_bits(pen_bits)
  );

  // regroup the alternate-function buses from per-function to per-pin
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      for (int a = 0; a < NUM_ALT; a++) begin
        lane_ao[i][a] = alt_out[a][i];
        lane_ae[i][a] = alt_oe[a][i];
        alt_in[a][i]  = lane_ai[i][a];
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    gpio_pinmux_lane u_lane (
      .gpio_out(out_bits[i]), .gpio_dir(dir_bits[i]),
      .fs0(fs0_bits[i]), .fs1(fs1_bits[i]), .od(od_bits[i]),
      .pen(pen_bits[i]), .psel(psel_bits[i]), .in_sync(sync_bits[i]),
      .alt_out(lane_ao[i]), .alt_oe(lane_ae[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
      .pull_up(pad_pull_up[i]), .pull_dn(pad_pull_dn[i]),
      .alt_in(lane_ai[i])
    );
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk
  import gpio_pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 56
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PINS-1:0]              pad_in,
  input logic [NUM_PINS-1:0]              pad_out,
  input logic [NUM_PINS-1:0]              pad_oe,
  input logic [NUM_PINS-1:0]              pad_pull_up,
  input logic [NUM_PINS-1:0]              pad_pull_dn,
  input logic [NUM_ALT-1:0][NUM_PINS-1:0] alt_in,
  input logic [NUM_PINS-1:0]              out_bits,
  input logic [NUM_PINS-1:0]              fs0_bits,
  input logic [NUM_PINS-1:0]              fs1_bits,
  input logic [NUM_PINS-1:0]              od_bits,
  input logic [NUM_PINS-1:0]              pen_bits,
  input logic [NUM_PINS-1:0]              sync_bits
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pull_up == '0 && pad_pull_dn == '0));

  a_r5_gpio_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ out_bits) & ~(fs0_bits | fs1_bits)) == '0);

  a_r7_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_bits) == '0);

  a_r8_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_up | pad_pull_dn) & ~pen_bits) == '0);

  a_r6_one_alt_input: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_in[0] & alt_in[1]) | (alt_in[0] & alt_in[2]) | (alt_in[1] & alt_in[2])) == '0);

  a_r6_alt_input_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_in[0] | alt_in[1] | alt_in[2]) & ~sync_bits) == '0);

  a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (sync_bits == $past(pad_in, 2)));
endmodule

bind gpio_pinmux gpio_pinmux_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
  .alt_in(alt_in), .out_bits(out_bits), .fs0_bits(fs0_bits),
  .fs1_bits(fs1_bits), .od_bits(od_bits), .pen_bits(pen_bits),
  .sync_bits(sync_bits)
);

// File: tb/gpio_pinmux_test.sv
module gpio_pinmux_test;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       addr;
  logic             wr_en;
  logic [15:0]      wr_data;
  logic [15:0]      rd_data;
  logic [55:0]      pad_in, pad_out, pad_oe, pu, pd;
  logic [2:0][55:0] alt_out, alt_oe, alt_in;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [15:0] e;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #2 clk = ~clk;

  gpio_pinmux uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_up(pu), .pad_pull_dn(pd), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: present an address and queue the value the requirements predict
  task automatic rd_exp(logic [7:0] a, logic [15:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare the read bus one step after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        rd_item_t it;
        it = sb.pop_front();
        chk($sformatf("%s read @%h", it.tag, it.a), 64'(rd_data), 64'(it.e));
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs[7];
    offs = '{'h00, 'h08, 'h0C, 'h10, 'h14, 'h1C, 'h20};
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: quiet pads after reset
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_out", 64'(pad_out), 64'h0);
    chk("R1 pull up", 64'(pu), 64'h0);
    chk("R1 pull dn", 64'(pd), 64'h0);
    rd_exp(8'h00, 16'h0, "R1");
    rd_exp(8'h98, 16'h0, "R1");
    rd_exp(8'h2C, 16'h0, "R1");

    // R2: every stored register of ports 0..2 reads back
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 7; k++) begin
        logic [15:0] v;
        v = 16'((p + 1) * 16'h1111) ^ 16'(k * 16'h0103);
        wr(8'(p * 'h30 + offs[k]), v);
        rd_exp(8'(p * 'h30 + offs[k]), v, "R2");
      end
    end
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 7; k++) wr(8'(p * 'h30 + offs[k]), 16'h0);

    // R4: unpopulated upper half of port 3
    wr(8'h90, 16'hFFFF);
    #1 chk("R4 pad_out[55:48]", 64'(pad_out[55:48]), 64'hFF);
    rd_exp(8'h90, 16'h00FF, "R4");
    // R3: relocated registers of port 3
    wr(8'h24, 16'hFFFF);
    rd_exp(8'h24, 16'h00FF, "R3");
    rd_exp(8'h14, 16'h0000, "R3");
    wr(8'h54, 16'h00AA);
    rd_exp(8'h54, 16'h00AA, "R3");
    rd_exp(8'h40, 16'h0000, "R3");
    rd_exp(8'hB0, 16'h0000, "R3");
    // R10: unmapped slot
    wr(8'hA0, 16'hFFFF);
    rd_exp(8'hA0, 16'h0000, "R10");
    wr(8'h90, 16'h0); wr(8'h24, 16'h0); wr(8'h54, 16'h0);

    // R5: GPIO mode
    wr(8'h00, 16'hA5A5);
    wr(8'h08, 16'h00FF);
    #1;
    chk("R5 pad_out", 64'(pad_out[15:0]), 64'hA5A5);
    chk("R5 pad_oe", 64'(pad_oe[15:0]), 64'h00FF);
    // R7: open drain in GPIO mode
    wr(8'h14, 16'h000F);
    #1;
    chk("R7 pad_oe", 64'(pad_oe[15:0]), 64'h00FA);
    chk("R7 pad_out", 64'(pad_out[15:0]), 64'hA5A5);

    // R6: codes 0..3 on the four nibbles of port 1
    alt_out[0] = '1; alt_out[1] = '0; alt_out[2] = {28{2'b01}};
    alt_oe[0]  = '0; alt_oe[1]  = '1; alt_oe[2]  = '1;
    wr(8'h3C, 16'hF0F0);
    wr(8'h40, 16'hFF00);
    #1;
    chk("R6 pad_out", 64'(pad_out[31:16]), 64'h50F0);
    chk("R6 pad_oe", 64'(pad_oe[31:16]), 64'hFF00);
    pad_in[31:16] = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R6 alt_in1", 64'(alt_in[0][31:16]), 64'h00F0);
    chk("R6 alt_in2", 64'(alt_in[1][31:16]), 64'h0F00);
    chk("R6 alt_in3", 64'(alt_in[2][31:16]), 64'hF000);
    rd_exp(8'h34, 16'hFFFF, "R9");
    // R6 and R3: pin 48 on code 3 via the relocated high select
    wr(8'h9C, 16'h0001);
    wr(8'h54, 16'h0001);
    #1;
    chk("R6 pin48 out", 64'(pad_out[48]), 64'h1);
    chk("R6 pin48 oe", 64'(pad_oe[48]), 64'h1);
    wr(8'h24, 16'h0001);
    #1 chk("R7 pin48 drain", 64'(pad_oe[48]), 64'h0);

    // R8: pulls on port 2 and port 3
    wr(8'h80, 16'h00FF);
    wr(8'h7C, 16'h0F0F);
    #1;
    chk("R8 pull up", 64'(pu[47:32]), 64'h000F);
    chk("R8 pull dn", 64'(pd[47:32]), 64'h00F0);
    wr(8'h2C, 16'h0003);
    wr(8'h28, 16'h0001);
    #1;
    chk("R8 port3 up", 64'(pu[49:48]), 64'h1);
    chk("R8 port3 dn", 64'(pd[49:48]), 64'h2);

    // R9: two-clock input latency
    pad_in[15:0] = 16'h1234;
    rd_exp(8'h04, 16'h0000, "R9");
    rd_exp(8'h04, 16'h1234, "R9");
    // R10: input register ignores writes
    wr(8'h04, 16'hFFFF);
    rd_exp(8'h04, 16'h1234, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule